// File: doc/BRIEF.md
# Framed Serial PCM Port

This block is the digital serial side of a voice codec. One bit clock (nominally 2.048 MHz) and one active-low frame strobe run it. When the strobe is sampled low at a rising clock edge and the mode input is low, the block opens an eight-bit PCM window. In that window it drives the outgoing PCM byte, taken from the encoder, onto a serial output with an output enable. At the same time it collects a received PCM byte from the serial input and hands it to the decoder as a parallel word.

Outgoing bits change on rising edges and incoming bits are sampled on falling edges. Both travel most significant bit (the sign bit) first. A strobe that is sampled low while the mode input is high opens a control window instead. That window shifts eight bits from a separate control serial input into a control register, and the PCM output and input stay inhibited. A host can use the PCM window early in a frame and reopen the strobe later in the same frame to load control.

The sequencer has four states. IDLE waits for the strobe. PCM runs a PCM window and CTL runs a control window. HOLD waits for the strobe to go high after a window ends while the strobe is still low. The transitions are:
- IDLE→PCM: strobe low, mode low.
- IDLE→CTL: strobe low, mode high.
- PCM→IDLE or PCM→HOLD: the eighth bit completes, or the window aborts. It goes to IDLE if the strobe is high and to HOLD if it is still low.
- CTL→IDLE or CTL→HOLD: the same rules as PCM.
- HOLD→IDLE: the strobe is sampled high.

Top module: `pcm_frame_port`

## Requirements
- R1: After reset, `pcm_tx_oe` is 0, `dec_valid` is 0, and `dec_word` and `ctl_word` are 0x00.
- R2: At the first rising edge where `frame_n` is sampled 0 and `ctl_mode` is 0 (IDLE→PCM), `pcm_tx_oe` goes to 1 and `pcm_tx_out` shows bit 7 of `enc_word`.
- R3: While `pcm_tx_oe` is 1, each further rising edge moves `pcm_tx_out` to the next lower bit. Bits 7 down to 0 are sent, and `pcm_tx_oe` returns to 0 at the rising edge that ends the eighth bit period.
- R4: The outgoing byte is the value of `enc_word` at the activation edge. Later changes of `enc_word` during the window do not alter the bits sent.
- R5: `pcm_rx_in` is sampled on falling edges. The first falling edge after activation gives bit 7 of the received byte, and the eighth gives bit 0. At the rising edge that ends the window, `dec_word` takes the byte and `dec_valid` is 1 for exactly one clock cycle.
- R6: If `frame_n` is sampled 1 at any of the first seven rising edges after activation, the PCM window aborts at that edge. `pcm_tx_oe` drops, `dec_valid` does not pulse, and `dec_word` keeps its old value.
- R7: A window opened with `ctl_mode` 1 (IDLE→CTL) shifts eight bits from `ctl_ser_in` (falling-edge sampled, first bit to bit 7) and loads them into `ctl_word` at the rising edge after the eighth bit. `ctl_word` does not change before that edge. `pcm_tx_oe` stays 0 and `dec_valid` does not pulse.
- R8: A control window aborted early, by `frame_n` sampled 1 or `ctl_mode` sampled 0 at one of its first seven edges after activation, leaves `ctl_word` unchanged.
- R9: `ctl_mode` sampled 1 at any of the first seven rising edges of a PCM window aborts it as in R6. `pcm_tx_oe` is 0 after any edge where `ctl_mode` is 1.
- R10: After a window completes or aborts with `frame_n` still 0 (HOLD), no new window opens until `frame_n` has been sampled 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data launched on rising, captured on falling edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe, sampled on rising edges |
| ctl_mode | input | 1 | 0: strobe opens a PCM window; 1: strobe opens a control window |
| pcm_rx_in | input | 1 | Received PCM serial data |
| pcm_tx_out | output | 1 | Transmitted PCM serial data (0 when not enabled) |
| pcm_tx_oe | output | 1 | Output enable for the three-state PCM output pad |
| ctl_ser_in | input | 1 | Control serial data |
| enc_word | input | 8 | Parallel byte from the encoder |
| dec_word | output | 8 | Last complete received PCM byte for the decoder |
| dec_valid | output | 1 | One-cycle pulse when `dec_word` is updated |
| ctl_word | output | 8 | Control register contents |

## Verification
The bench drives whole windows with several byte patterns. It checks every transmitted bit a few nanoseconds after the rising edge that launches it, and it changes `enc_word` right after activation. A design that sampled the encoder on each bit would then send corrupted bytes. Aborts are forced by raising the strobe, and separately by raising the mode input, in the middle of a PCM window and a control window. A design that committed partial data would show a spurious `dec_valid` or a changed `ctl_word`. A window is also completed with the strobe held low. A design that skipped the HOLD state would restart a window at once and turn the output enable back on.

// File: rtl/fpp_pkg.sv
package fpp_pkg;

    // Sequencer states of the framed serial port.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for the strobe to be sampled low
        ST_PCM  = 2'd1,   // PCM transfer window in progress
        ST_CTL  = 2'd2,   // control-word load window in progress
        ST_HOLD = 2'd3    // window over, waiting for the strobe to go high
    } port_state_t;

endpackage

// File: rtl/fpp_serializer.sv
// Parallel-in, serial-out register, MSB first, advanced on rising edges.
module fpp_serializer #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] par_in,
    output logic              ser_out
);

    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= par_in;                       // snapshot at window start
        end else if (shift) begin
            sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    assign ser_out = sh_q[WORD_W-1];

endmodule

// File: rtl/fpp_deserializer.sv
// Serial-in, parallel-out register. The serial line is sampled on falling
// edges; the sampled bit is folded in on the following rising edge. The
// parallel word only changes on commit, which also folds in the last bit.
module fpp_deserializer #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              shift,
    input  logic              commit,
    output logic [WORD_W-1:0] par_out
);

    localparam int SH_W = WORD_W - 1;

    logic            smp_q;
    logic [SH_W-1:0] sh_q;

    // Falling-edge capture of the serial line.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= 1'b0;
        end else begin
            smp_q <= ser_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            par_out <= '0;
        end else begin
            if (shift) begin
                sh_q <= {sh_q[SH_W-2:0], smp_q};
            end
            if (commit) begin
                par_out <= {sh_q, smp_q};
            end
        end
    end

endmodule

// File: rtl/fpp_sequencer.sv
// Window sequencer: decides when a PCM or control window opens, advances,
// completes or aborts.
module fpp_sequencer
    import fpp_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic ctl_mode,
    output logic tx_load,
    output logic tx_shift,
    output logic pcm_shift,
    output logic pcm_commit,
    output logic ctl_shift,
    output logic ctl_commit,
    output logic tx_oe,
    output logic rx_done
);

    localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    port_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             last_bit;
    port_state_t      after_window;

    assign last_bit     = (cnt_q == LAST_BIT);
    assign after_window = frame_n ? ST_IDLE : ST_HOLD;

    // Next-state and strobe decode.
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        tx_load    = 1'b0;
        tx_shift   = 1'b0;
        pcm_shift  = 1'b0;
        pcm_commit = 1'b0;
        ctl_shift  = 1'b0;
        ctl_commit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!frame_n) begin
                    cnt_d = '0;
                    if (ctl_mode) begin
                        state_d = ST_CTL;
                    end else begin
                        state_d = ST_PCM;
                        tx_load = 1'b1;
                    end
                end
            end
            ST_PCM: begin
                if (last_bit) begin
                    pcm_commit = 1'b1;
                    state_d    = after_window;
                end else if (frame_n || ctl_mode) begin
                    state_d    = after_window;   // abort, partial byte dropped
                end else begin
                    pcm_shift  = 1'b1;
                    tx_shift   = 1'b1;
                    cnt_d      = cnt_q + 1'b1;
                end
            end
            ST_CTL: begin
                if (last_bit) begin
                    ctl_commit = 1'b1;
                    state_d    = after_window;
                end else if (frame_n || !ctl_mode) begin
                    state_d    = after_window;   // abort, register kept
                end else begin
                    ctl_shift  = 1'b1;
                    cnt_d      = cnt_q + 1'b1;
                end
            end
            ST_HOLD: begin
                if (frame_n) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_oe   <= 1'b0;
            rx_done <= 1'b0;
        end else begin
            tx_oe   <= (state_d == ST_PCM);
            rx_done <= pcm_commit;
        end
    end

endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              ctl_mode,
    input  logic              pcm_rx_in,
    output logic              pcm_tx_out,
    output logic              pcm_tx_oe,
    input  logic              ctl_ser_in,
    input  logic [WORD_W-1:0] enc_word,
    output logic [WORD_W-1:0] dec_word,
    output logic              dec_valid,
    output logic [WORD_W-1:0] ctl_word
);

    logic tx_load, tx_shift, pcm_shift, pcm_commit, ctl_shift, ctl_commit;
    logic tx_bit;

    fpp_sequencer #(.WORD_W(WORD_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .ctl_mode   (ctl_mode),
        .tx_load    (tx_load),
        .tx_shift   (tx_shift),
        .pcm_shift  (pcm_shift),
        .pcm_commit (pcm_commit),
        .ctl_shift  (ctl_shift),
        .ctl_commit (ctl_commit),
        .tx_oe      (pcm_tx_oe),
        .rx_done    (dec_valid)
    );

    fpp_serializer #(.WORD_W(WORD_W)) i_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tx_load),
        .shift   (tx_shift),
        .par_in  (enc_word),
        .ser_out (tx_bit)
    );

    fpp_deserializer #(.WORD_W(WORD_W)) i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_in  (pcm_rx_in),
        .shift   (pcm_shift),
        .commit  (pcm_commit),
        .par_out (dec_word)
    );

    fpp_deserializer #(.WORD_W(WORD_W)) i_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_in  (ctl_ser_in),
        .shift   (ctl_shift),
        .commit  (ctl_commit),
        .par_out (ctl_word)
    );

    assign pcm_tx_out = pcm_tx_oe & tx_bit;

endmodule

// File: rtl/fpp_checker.sv
module fpp_checker #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n,
    input logic              ctl_mode,
    input logic              pcm_tx_oe,
    input logic              dec_valid,
    input logic [WORD_W-1:0] ctl_word
);

    assert_open_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcm_tx_oe) |-> ($past(!frame_n) && $past(!ctl_mode)));

    assert_strobe_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n && pcm_tx_oe) |=> !pcm_tx_oe);

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    assert_valid_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !pcm_tx_oe);

    assert_mode_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_mode |=> !pcm_tx_oe);

    assert_ctl_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_tx_oe |=> $stable(ctl_word));

endmodule

bind pcm_frame_port fpp_checker #(.WORD_W(WORD_W)) i_fpp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .ctl_mode  (ctl_mode),
    .pcm_tx_oe (pcm_tx_oe),
    .dec_valid (dec_valid),
    .ctl_word  (ctl_word)
);

// File: tb/test_pcm_frame_port.sv
`timescale 1ns/1ps
module test_pcm_frame_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_n = 1'b1;
    logic       ctl_mode = 1'b0;
    logic       pcm_rx_in = 1'b0;
    logic       ctl_ser_in = 1'b0;
    logic [7:0] enc_word = 8'h00;
    logic       pcm_tx_out, pcm_tx_oe, dec_valid;
    logic [7:0] dec_word, ctl_word;

    int n_run = 0;
    int n_fail = 0;
    int n_valid = 0;
    bit done = 1'b0;
    logic [7:0] exp_dec = 8'h00;
    logic [7:0] exp_ctl = 8'h00;

    always #10 clk = ~clk;

    pcm_frame_port i_pcm_frame_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .ctl_mode   (ctl_mode),
        .pcm_rx_in  (pcm_rx_in),
        .pcm_tx_out (pcm_tx_out),
        .pcm_tx_oe  (pcm_tx_oe),
        .ctl_ser_in (ctl_ser_in),
        .enc_word   (enc_word),
        .dec_word   (dec_word),
        .dec_valid  (dec_valid),
        .ctl_word   (ctl_word)
    );

    // Count decoder valid pulses between rising edges.
    always @(negedge clk) if (dec_valid) n_valid++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // R1: reset state.
    task automatic t_reset();
        #5;
        chk("R1 oe", pcm_tx_oe, 0);
        chk("R1 valid", dec_valid, 0);
        chk("R1 dec_word", dec_word, 0);
        chk("R1 ctl_word", ctl_word, 0);
    endtask

    // Full PCM window; R2, R3, R4, R5, optionally R10 (strobe held low).
    task automatic t_pcm(input logic [7:0] enc, input logic [7:0] rx, input bit hold_low);
        int v0;
        @(posedge clk); #2;
        frame_n = 1'b0; ctl_mode = 1'b0; enc_word = enc;
        v0 = n_valid;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #2;
            pcm_rx_in = rx[7-i];
            enc_word  = ~enc;                      // R4: must not leak
            if (i == 7 && !hold_low) frame_n = 1'b1;
            #3;
            chk(i == 0 ? "R2 oe" : "R3 oe", pcm_tx_oe, 1);
            chk(i == 0 ? "R2 msb" : "R3 R4 bit", pcm_tx_out, enc[7-i]);
        end
        @(posedge clk); #5;
        chk("R3 oe off", pcm_tx_oe, 0);
        chk("R5 valid", dec_valid, 1);
        chk("R5 dec_word", dec_word, rx);
        exp_dec = rx;
        if (hold_low) begin
            for (int k = 0; k < 3; k++) begin
                @(posedge clk); #5;
                chk("R10 no reopen", pcm_tx_oe, 0);
            end
            frame_n = 1'b1;
        end
        @(posedge clk); #5;
        chk("R5 single pulse", n_valid - v0, 1);
        chk("R5 valid low", dec_valid, 0);
    endtask

    // PCM window aborted after bit k by strobe (R6) or mode (R9).
    task automatic t_pcm_abort(input logic [7:0] enc, input logic [7:0] rx, input int k, input bit by_mode);
        int v0;
        @(posedge clk); #2;
        frame_n = 1'b0; ctl_mode = 1'b0; enc_word = enc;
        v0 = n_valid;
        for (int i = 0; i <= k; i++) begin
            @(posedge clk); #2;
            pcm_rx_in = rx[7-i];
            if (i == k) begin
                if (by_mode) ctl_mode = 1'b1; else frame_n = 1'b1;
            end
            #3;
            chk(by_mode ? "R9 bit" : "R6 bit", pcm_tx_out, enc[7-i]);
        end
        @(posedge clk); #5;
        chk(by_mode ? "R9 oe off" : "R6 oe off", pcm_tx_oe, 0);
        repeat (10) @(posedge clk);
        #5;
        chk(by_mode ? "R9 no valid" : "R6 no valid", n_valid - v0, 0);
        chk(by_mode ? "R9 dec kept" : "R6 dec kept", dec_word, exp_dec);
        chk(by_mode ? "R10 held" : "R6 oe idle", pcm_tx_oe, 0);
        frame_n = 1'b1; ctl_mode = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    // Control window; abort_at < 7 raises the strobe after that bit (R8).
    task automatic t_ctl(input logic [7:0] val, input logic [7:0] enc, input int abort_at);
        int v0;
        @(posedge clk); #2;
        frame_n = 1'b0; ctl_mode = 1'b1; enc_word = enc;
        v0 = n_valid;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #2;
            ctl_ser_in = val[7-i];
            #3;
            chk("R7 pcm inhibited", pcm_tx_oe, 0);
            chk("R7 ctl not early", ctl_word, exp_ctl);
            if (i == 7 || i == abort_at) begin
                frame_n = 1'b1;
                break;
            end
        end
        @(posedge clk); #5;
        if (abort_at < 7) begin
            chk("R8 ctl kept", ctl_word, exp_ctl);
        end else begin
            exp_ctl = val;
            chk("R7 ctl loaded", ctl_word, val);
        end
        chk("R7 no valid", n_valid - v0, 0);
        chk("R7 dec kept", dec_word, exp_dec);
        ctl_mode = 1'b0;
        @(posedge clk);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        #2 rst_n = 1'b1;
        t_pcm(8'hA5, 8'h3C, 1'b0);
        t_pcm(8'h81, 8'hC3, 1'b0);
        t_pcm(8'h7E, 8'h01, 1'b1);
        t_pcm(8'hFF, 8'h80, 1'b0);
        t_pcm_abort(8'h96, 8'hF0, 3, 1'b0);
        t_pcm_abort(8'h5A, 8'h0F, 2, 1'b1);
        t_ctl(8'hB4, 8'h11, 8);
        t_ctl(8'h2D, 8'h22, 4);
        t_pcm(8'h00, 8'h69, 1'b0);
        t_ctl(8'h4B, 8'h33, 8);
        finish_run();
    end

endmodule